// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block holds the power-mode field that software writes to put the system into a low-power state. It also brings the system back to run mode when a wakeup arrives. When the core is in run mode, a register-bus write with a valid low-power code gates the core clock and raises the request line for the selected state. The controller then waits for the wakeup source that belongs to that state. When the wakeup arrives, the controller clears the mode field, re-enables the core clock and emits a single-cycle wake pulse. If the state being left was sleep or deep sleep, it also emits a reset-request pulse, because leaving those states restarts the system instead of resuming it.

Core idle waits on the interrupt lines. By default the interrupt mask does not block an idle wakeup, so any interrupt raised at its source wakes the core. A separate control input turns mask checking back on. The two standby states, sleep and deep sleep wait on the wakeup-enabled event lines instead. If the wakeup for the requested state is already present when the write occurs, the controller does not leave run mode.

Top module: `pm_lowpower_ctrl`

## Requirements
- R1: After reset, `mode_cur` is 0, `core_clk_en` is 1, and `disp_hold`, `stby_req`, `sleep_req`, `dsleep_req`, `wake_pulse` and `rst_req` are all 0.
- R2: In run mode (code 0), a write with code 1 (idle), 2 (standby with display refresh), 3 (standby), 6 (sleep) or 7 (deep sleep) and no pending wakeup makes `mode_cur` show that code one cycle later, with `core_clk_en` low.
- R3: In run mode, writes of code 0, 4 or 5 are ignored. A write made while in any low-power mode is also ignored.
- R4: In idle, only the core clock is stopped: `disp_hold`, `stby_req`, `sleep_req` and `dsleep_req` all stay 0.
- R5: In idle with `idle_mask_en` = 0, any set bit of `irq_raw` wakes the core, whatever `irq_mask` holds.
- R6: In idle with `idle_mask_en` = 1, only a bit set in both `irq_raw` and `irq_mask` wakes the core (a mask bit of 1 lets its line through). A masked interrupt leaves the mode unchanged.
- R7: In modes 2, 3, 6 and 7, any set bit of `wake_evt` wakes the system, and `irq_raw` has no effect.
- R8: When a wakeup is sampled at a clock edge, `mode_cur` is 0 and `core_clk_en` is 1 after that edge, and `wake_pulse` is high for exactly that one cycle.
- R9: A write whose target state's wakeup condition is already true at the write edge leaves the controller in run mode, with `core_clk_en` high and no wake pulse.
- R10: `rst_req` pulses together with `wake_pulse` only when the state being left is sleep or deep sleep.
- R11: `stby_req` is high in modes 2 and 3, `disp_hold` is high only in mode 2, `sleep_req` is high only in mode 6, and `dsleep_req` is high only in mode 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mode-field write strobe |
| wr_data | input | 3 | Mode code being written |
| irq_raw | input | N_IRQ | Interrupt lines asserted at their sources |
| irq_mask | input | N_IRQ | Interrupt mask, 1 = line allowed |
| idle_mask_en | input | 1 | 1 = idle wakeup honours `irq_mask` |
| wake_evt | input | N_WAKE | Wakeup-enabled event lines |
| core_clk_en | output | 1 | Core clock enable |
| mode_cur | output | 3 | Current mode code |
| disp_hold | output | 1 | Keep display refresh running |
| stby_req | output | 1 | Standby request |
| sleep_req | output | 1 | Sleep request |
| dsleep_req | output | 1 | Deep-sleep request |
| wake_pulse | output | 1 | One-cycle pulse on leaving a low-power mode |
| rst_req | output | 1 | One-cycle reset request on leaving sleep or deep sleep |

## Verification
The assertions assume that `wr_data` carries a defined 3-bit value whenever `wr_en` is high. They also assume that the interrupt and wakeup lines are already synchronised to `clk`, so each value holds for a whole cycle. The stimulus changes every input just after a rising edge and holds it until the next one. It keeps interrupts and events sparse so that low-power modes are entered and held for several cycles. Directed cases add pending-at-write wakeups, masked interrupts with mask checking on and off, and invalid codes.

// File: rtl/pm_pkg.sv
// Package: shared mode codes and helpers for the low-power mode controller.
// Assumes a 3-bit mode field; codes 4 and 5 are reserved and never accepted.
package pm_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_RUN       = 3'd0;
    localparam logic [MODE_W-1:0] MODE_IDLE      = 3'd1;
    localparam logic [MODE_W-1:0] MODE_STBY_DISP = 3'd2;
    localparam logic [MODE_W-1:0] MODE_STBY      = 3'd3;
    localparam logic [MODE_W-1:0] MODE_SLEEP     = 3'd6;
    localparam logic [MODE_W-1:0] MODE_DEEP      = 3'd7;

    // True for any code that selects a low-power state.
    function automatic logic is_lp_code(input logic [MODE_W-1:0] c);
        return (c == MODE_IDLE) || (c == MODE_STBY_DISP) || (c == MODE_STBY) ||
               (c == MODE_SLEEP) || (c == MODE_DEEP);
    endfunction

    // True for states whose exit restarts the system.
    function automatic logic is_reset_exit(input logic [MODE_W-1:0] c);
        return (c == MODE_SLEEP) || (c == MODE_DEEP);
    endfunction
endpackage

// File: rtl/pm_wake_eval.sv
// Module: pm_wake_eval
// Forms the two wakeup conditions: the idle one from the interrupt lines
// (mask applied only when mask_en is set) and the external one from the
// wakeup-enabled event lines. Purely combinational; inputs assumed synchronous.
module pm_wake_eval #(
    parameter int N_IRQ  = 8,
    parameter int N_WAKE = 4
) (
    input  logic [N_IRQ-1:0]  irq_raw,
    input  logic [N_IRQ-1:0]  irq_mask,
    input  logic              mask_en,
    input  logic [N_WAKE-1:0] wake_evt,
    output logic              idle_wake,
    output logic              ext_wake
);
    logic [N_IRQ-1:0] irq_qual;

    // Per-line qualification: the mask only matters when mask checking is on.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_qual
        assign irq_qual[i] = irq_raw[i] & (irq_mask[i] | ~mask_en);
    end

    // Reduce the qualified lines and the event lines to single conditions.
    always_comb begin
        idle_wake = |irq_qual;
        ext_wake  = |wake_evt;
    end
endmodule

// File: rtl/pm_req_decode.sv
// Module: pm_req_decode
// Turns the held mode code into the per-state request outputs.
// Assumes the code is one of the accepted values; others give all-low.
module pm_req_decode
    import pm_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              disp_hold,
    output logic              stby_req,
    output logic              sleep_req,
    output logic              dsleep_req
);
    // Decode the mode field into one request per external state group.
    always_comb begin
        disp_hold  = (mode == MODE_STBY_DISP);
        stby_req   = (mode == MODE_STBY_DISP) || (mode == MODE_STBY);
        sleep_req  = (mode == MODE_SLEEP);
        dsleep_req = (mode == MODE_DEEP);
    end
endmodule

// File: rtl/pm_mode_fsm.sv
// Module: pm_mode_fsm
// Holds the mode field, accepts writes only in run mode, refuses entry
// when the target state's wakeup is already pending, and returns to run on
// the wakeup that belongs to the held state. Drives the core clock enable
// and the wake and reset-request pulses. Synchronous active-low reset.
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              idle_wake,
    input  logic              ext_wake,
    output logic [MODE_W-1:0] mode_q,
    output logic              core_clk_en,
    output logic              wake_pulse,
    output logic              rst_req
);
    logic wake_now;
    logic pend_at_wr;
    logic accept_wr;

    // Wakeup for the state currently held, and for the state being requested.
    always_comb begin
        wake_now   = (mode_q == MODE_IDLE) ? idle_wake : ext_wake;
        pend_at_wr = (wr_data == MODE_IDLE) ? idle_wake : ext_wake;
        accept_wr  = (mode_q == MODE_RUN) && wr_en && is_lp_code(wr_data) && !pend_at_wr;
    end

    // Mode register, clock enable and exit pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_RUN;
            core_clk_en <= 1'b1;
            wake_pulse  <= 1'b0;
            rst_req     <= 1'b0;
        end else if (mode_q == MODE_RUN) begin
            wake_pulse <= 1'b0;
            rst_req    <= 1'b0;
            if (accept_wr) begin
                mode_q      <= wr_data;
                core_clk_en <= 1'b0;
            end
        end else if (wake_now) begin
            mode_q      <= MODE_RUN;
            core_clk_en <= 1'b1;
            wake_pulse  <= 1'b1;
            rst_req     <= is_reset_exit(mode_q);
        end else begin
            wake_pulse <= 1'b0;
            rst_req    <= 1'b0;
        end
    end

    AST_GATED_OUT_OF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RUN) |-> !core_clk_en);                                   // R2
    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && wr_en && !is_lp_code(wr_data)) |=> (mode_q == MODE_RUN)); // R3
    AST_LP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RUN && !wake_now) |=> $stable(mode_q));                   // R3
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && idle_wake) |=> (mode_q == MODE_RUN && core_clk_en && wake_pulse)); // R8
    AST_EXT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RUN && mode_q != MODE_IDLE && ext_wake) |=> (mode_q == MODE_RUN)); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);                                              // R8
    AST_PENDING_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && wr_en && pend_at_wr) |=> (mode_q == MODE_RUN && core_clk_en && !wake_pulse)); // R9
    AST_RST_ONLY_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (wake_pulse && is_reset_exit($past(mode_q))));                // R10
endmodule

// File: rtl/pm_lowpower_ctrl.sv
// Module: pm_lowpower_ctrl (top)
// Low-power mode entry controller: wakeup evaluation, mode register with
// entry/exit sequencing, and request decode. All inputs assumed synchronous
// to clk; synchronous active-low reset.
module pm_lowpower_ctrl
    import pm_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int N_WAKE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_data,
    input  logic [N_IRQ-1:0]  irq_raw,
    input  logic [N_IRQ-1:0]  irq_mask,
    input  logic              idle_mask_en,
    input  logic [N_WAKE-1:0] wake_evt,
    output logic              core_clk_en,
    output logic [2:0]        mode_cur,
    output logic              disp_hold,
    output logic              stby_req,
    output logic              sleep_req,
    output logic              dsleep_req,
    output logic              wake_pulse,
    output logic              rst_req
);
    logic idle_wake;
    logic ext_wake;

    pm_wake_eval #(.N_IRQ(N_IRQ), .N_WAKE(N_WAKE)) u_wake (
        .irq_raw(irq_raw), .irq_mask(irq_mask), .mask_en(idle_mask_en),
        .wake_evt(wake_evt), .idle_wake(idle_wake), .ext_wake(ext_wake)
    );

    pm_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .idle_wake(idle_wake), .ext_wake(ext_wake), .mode_q(mode_cur),
        .core_clk_en(core_clk_en), .wake_pulse(wake_pulse), .rst_req(rst_req)
    );

    pm_req_decode u_dec (
        .mode(mode_cur), .disp_hold(disp_hold), .stby_req(stby_req),
        .sleep_req(sleep_req), .dsleep_req(dsleep_req)
    );

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stby_req, sleep_req, dsleep_req}));                             // R11
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_IDLE) |-> !(stby_req || sleep_req || dsleep_req || disp_hold)); // R4
endmodule

// File: tb/sim_pm_lowpower_ctrl.sv
`timescale 1ns/1ps
module sim_pm_lowpower_ctrl;
    localparam int N_IRQ  = 8;
    localparam int N_WAKE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic [N_IRQ-1:0] irq_raw = '0;
    logic [N_IRQ-1:0] irq_mask = '0;
    logic idle_mask_en = 1'b0;
    logic [N_WAKE-1:0] wake_evt = '0;
    logic core_clk_en, disp_hold, stby_req, sleep_req, dsleep_req, wake_pulse, rst_req;
    logic [2:0] mode_cur;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [2:0] e_mode = 3'd0;
    logic e_clk = 1'b1, e_wp = 1'b0, e_rr = 1'b0;

    always #2.5 clk = ~clk;

    pm_lowpower_ctrl #(.N_IRQ(N_IRQ), .N_WAKE(N_WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_raw(irq_raw), .irq_mask(irq_mask), .idle_mask_en(idle_mask_en),
        .wake_evt(wake_evt), .core_clk_en(core_clk_en), .mode_cur(mode_cur),
        .disp_hold(disp_hold), .stby_req(stby_req), .sleep_req(sleep_req),
        .dsleep_req(dsleep_req), .wake_pulse(wake_pulse), .rst_req(rst_req)
    );

    function automatic bit lp_ok(input logic [2:0] c);
        return c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd6 || c == 3'd7;
    endfunction

    function automatic bit idle_cond();
        return |(irq_raw & (idle_mask_en ? irq_mask : {N_IRQ{1'b1}}));
    endfunction

    function automatic bit wake_for(input logic [2:0] m);
        return (m == 3'd1) ? idle_cond() : (|wake_evt);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all();
        chk("R2 mode", mode_cur, e_mode);
        chk("R8 core_clk_en", core_clk_en, e_clk);
        chk("R8 wake_pulse", wake_pulse, e_wp);
        chk("R10 rst_req", rst_req, e_rr);
        chk("R11 stby_req", stby_req, (e_mode == 3'd2 || e_mode == 3'd3));
        chk("R11 disp_hold", disp_hold, (e_mode == 3'd2));
        chk("R11 sleep_req", sleep_req, (e_mode == 3'd6));
        chk("R11 dsleep_req", dsleep_req, (e_mode == 3'd7));
    endtask

    // Advance the model from current inputs, clock once, compare.
    task automatic step();
        logic [2:0] nm = e_mode;
        logic nc = e_clk, nw = 1'b0, nr = 1'b0;
        if (e_mode == 3'd0) begin
            if (wr_en && lp_ok(wr_data) && !wake_for(wr_data)) begin
                nm = wr_data; nc = 1'b0;
            end
        end else if (wake_for(e_mode)) begin
            nm = 3'd0; nc = 1'b1; nw = 1'b1; nr = (e_mode == 3'd6 || e_mode == 3'd7);
        end
        @(posedge clk);
        #1;
        e_mode = nm; e_clk = nc; e_wp = nw; e_rr = nr;
        chk_all();
    endtask

    task automatic drive(input bit we, input logic [2:0] d, input logic [N_IRQ-1:0] ir,
                         input logic [N_IRQ-1:0] mk, input bit me, input logic [N_WAKE-1:0] we2);
        wr_en = we; wr_data = d; irq_raw = ir; irq_mask = mk; idle_mask_en = me; wake_evt = we2;
        step();
    endtask

    task automatic quiet(); drive(0, 0, '0, '0, 0, '0); endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned sd;
        sd = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode", mode_cur, 0);
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 outputs", {disp_hold, stby_req, sleep_req, dsleep_req, wake_pulse, rst_req}, 0);

        // R3 invalid codes ignored
        drive(1, 3'd4, '0, '0, 0, '0); chk("R3 code4", mode_cur, 0);
        drive(1, 3'd5, '0, '0, 0, '0); chk("R3 code5", mode_cur, 0);
        drive(1, 3'd0, '0, '0, 0, '0); chk("R3 code0", mode_cur, 0);

        // R2/R4 idle entry, R6 masked interrupt ignored with mask checking on
        drive(1, 3'd1, '0, '0, 1, '0); chk("R2 idle entry", mode_cur, 1);
        chk("R4 idle requests", {disp_hold, stby_req, sleep_req, dsleep_req}, 0);
        drive(1, 3'd3, 8'h01, 8'hFE, 1, 4'h1);
        chk("R6 masked irq held", mode_cur, 1);
        chk("R3 write in lp", mode_cur, 1);
        drive(0, 0, 8'h01, 8'h01, 1, '0); chk("R6 unmasked wake", mode_cur, 0);
        chk("R8 pulse", wake_pulse, 1);
        quiet(); chk("R8 pulse single", wake_pulse, 0);

        // R5 idle wakes despite mask when checking is off
        drive(1, 3'd1, '0, '0, 0, '0);
        drive(0, 0, 8'h80, 8'h00, 0, '0); chk("R5 unmasked-by-default wake", mode_cur, 0);
        quiet();

        // R7 sleep ignores irq, wakes on event; R10 reset request
        drive(1, 3'd6, '0, '0, 0, '0); chk("R7 sleep entry", mode_cur, 6);
        drive(0, 0, 8'hFF, 8'hFF, 0, '0); chk("R7 irq ignored", mode_cur, 6);
        drive(0, 0, '0, '0, 0, 4'h8); chk("R10 rst on sleep exit", rst_req, 1);
        quiet();
        drive(1, 3'd7, '0, '0, 0, '0);
        drive(0, 0, '0, '0, 0, 4'h2); chk("R10 rst on deep exit", rst_req, 1);
        quiet();
        drive(1, 3'd2, '0, '0, 0, '0); chk("R11 disp_hold", disp_hold, 1);
        drive(0, 0, '0, '0, 0, 4'h4); chk("R10 no rst on standby exit", rst_req, 0);
        quiet();

        // R9 pending wakeup at write
        drive(1, 3'd3, '0, '0, 0, 4'h1);
        chk("R9 stays run", mode_cur, 0);
        chk("R9 clock on", core_clk_en, 1);
        chk("R9 no pulse", wake_pulse, 0);
        drive(1, 3'd1, 8'h04, 8'h00, 0, '0); chk("R9 idle pending", mode_cur, 0);

        // Constrained random: sparse wake sources so modes persist
        for (int i = 0; i < 3000; i++) begin
            logic [N_IRQ-1:0] ir = ($urandom % 6 == 0) ? N_IRQ'($urandom) : '0;
            logic [N_WAKE-1:0] we = ($urandom % 7 == 0) ? N_WAKE'($urandom) : '0;
            drive(($urandom % 3) == 0, 3'($urandom), ir, N_IRQ'($urandom), 1'($urandom), we);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule